// File: doc/BRIEF.md
# Phase-Programmable PWM Output Channel

This block produces one pulse-width-modulated output whose rising and falling points are both programmable within a free-running 12-bit period. A counter steps from 0 to 4095 and wraps. The channel raises its output when the count reaches a programmed start value and lowers it when the count reaches a programmed stop value. Because both points can be set anywhere in the period, the block controls phase as well as duty, to 1/4096 of the period. A start point above the stop point gives a pulse that spans the wrap.

Software writes the start and stop values one byte at a time through a byte-write port. The bytes land in shadow registers and reach the active comparators only at a commit. In bus-end mode the commit happens at a bus STOP event. In four-byte mode it happens on the write that completes all four bytes of the channel. A pad stage after the comparator can invert the level and drive the pin as totem-pole or open-drain. When the active-low enable is high, the pad stage instead shows a selectable idle state.

Top module: `pwm_phase_chan`

## Requirements
- R1: After reset the count output starts at 0, rises by one every clock and wraps from 4095 to 0.
- R2: In the clock after the count equals the active start value, the level goes high. In the clock after the count equals the active stop value, the level goes low. When start equals stop the level stays low.
- R3: Byte selector encoding: 0 = start low byte, 1 = start high byte, 2 = stop low byte, 3 = stop high byte. A high byte supplies value bits 11:8 from data bits 3:0. Data bits 7:4 of a high byte are ignored.
- R4: With `commit_on_ack` at 0, written bytes reach the active values only on a `bus_stop` pulse. Any number of bytes may be written, in any order, before that pulse. A byte written in the same cycle as the pulse is included.
- R5: With `commit_on_ack` at 1, the active values change only on the write that completes all four selectors since the last commit or stop. Fewer bytes change nothing. A `bus_stop` pulse clears the record of written bytes and does not commit.
- R6: Reset clears the shadow and active values to 0, so the level stays low until a commit.
- R7: While `out_en_n` is 0, `invert` at 1 flips the level shown at the pad.
- R8: With `drive_totem` at 1, the pad always drives (`pad_oe`=1, `pad_val`=level). With `drive_totem` at 0 (open-drain), a high level gives `pad_oe`=0 and a low level gives `pad_oe`=1, `pad_val`=0.
- R9: While `out_en_n` is 1, `idle_sel` sets the pad. 00 drives 0. 01 drives 1 in totem-pole mode and releases the pin in open-drain mode. 1x releases the pin. A released pin shows `pad_oe`=0 and `pad_val`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, also the acknowledge |
| wr_sel | input | 2 | Byte selector (R3) |
| wr_data | input | 8 | Byte to write |
| bus_stop | input | 1 | One-cycle bus STOP event |
| commit_on_ack | input | 1 | 0: commit at STOP, 1: commit on the fourth byte |
| invert | input | 1 | Invert the level while enabled |
| drive_totem | input | 1 | 1: totem-pole, 0: open-drain |
| idle_sel | input | 2 | Pad state while disabled |
| out_en_n | input | 1 | Active-low output enable |
| cnt_o | output | 12 | Current count |
| pad_val | output | 1 | Value driven on the pin |
| pad_oe | output | 1 | Pin drive enable, 0 = high impedance |

## Verification
Two functions can meet in one cycle: a byte write and the commit event. In bus-end mode the bench raises `wr_en` and `bus_stop` at the same clock edge and expects the new byte to be part of the committed value. In four-byte mode it checks that a stop pulse after three bytes clears the record, so a later single fourth byte commits nothing. In each case the bench judges the result by comparing the pad against a model of a full period, sampled on every cycle.

// File: rtl/pwm_phase_pkg.sv
// Shared types for the phase-programmable PWM channel.
package pwm_phase_pkg;
    typedef enum logic [1:0] {
        SEL_START_LO = 2'd0,
        SEL_START_HI = 2'd1,
        SEL_STOP_LO  = 2'd2,
        SEL_STOP_HI  = 2'd3
    } byte_sel_e;
endpackage

// File: rtl/pwm_period_cnt.sv
// Free-running period counter.
// Assumes: CNT_W >= 9. Wraps naturally at 2**CNT_W.
module pwm_period_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    // Count up every clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/pwm_shadow_regs.sv
// Shadow and active start/stop registers with the two commit policies.
// Assumes: wr_en is the acknowledge of one byte; bus_stop is a one-cycle pulse.
module pwm_shadow_regs
    import pwm_phase_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             bus_stop,
    input  logic             commit_on_ack,
    output logic [CNT_W-1:0] start_act,
    output logic [CNT_W-1:0] stop_act
);
    localparam int HI_W  = CNT_W - 8;
    localparam int NBYTE = 4;

    logic [CNT_W-1:0] start_sh, stop_sh, start_nx, stop_nx;
    logic [NBYTE-1:0] mask_q, mask_nx, mask_d;
    logic             commit;

    // Merge this cycle's byte into the shadow values.
    always_comb begin
        start_nx = start_sh;
        stop_nx  = stop_sh;
        if (wr_en) begin
            case (byte_sel_e'(wr_sel))
                SEL_START_LO: start_nx[7:0]       = wr_data;
                SEL_START_HI: start_nx[CNT_W-1:8] = wr_data[HI_W-1:0];
                SEL_STOP_LO:  stop_nx[7:0]        = wr_data;
                default:      stop_nx[CNT_W-1:8]  = wr_data[HI_W-1:0];
            endcase
        end
    end

    // Decide the commit and the next loaded-byte record.
    always_comb begin
        mask_nx = mask_q | (wr_en ? (NBYTE'(1) << wr_sel) : '0);
        commit  = commit_on_ack ? (wr_en && (&mask_nx)) : bus_stop;
        mask_d  = (!commit_on_ack || bus_stop || commit) ? '0 : mask_nx;
    end

    // Hold shadow values, record and active values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_sh  <= '0;
            stop_sh   <= '0;
            mask_q    <= '0;
            start_act <= '0;
            stop_act  <= '0;
        end else begin
            start_sh <= start_nx;
            stop_sh  <= stop_nx;
            mask_q   <= mask_d;
            if (commit) begin
                start_act <= start_nx;
                stop_act  <= stop_nx;
            end
        end
    end

    assert_hold_until_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_on_ack && !bus_stop) |=> ($stable(start_act) && $stable(stop_act)));
    assert_hold_without_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_on_ack && !wr_en) |=> ($stable(start_act) && $stable(stop_act)));
endmodule

// File: rtl/pwm_edge_cmp.sv
// Compares the count with the start and stop values and keeps the level.
// Assumes: stop has priority when both match.
module pwm_edge_cmp #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] start_v,
    input  logic [CNT_W-1:0] stop_v,
    output logic             level
);
    // Set on a start match, clear on a stop match.
    always_ff @(posedge clk) begin
        if (!rst_n)              level <= 1'b0;
        else if (cnt == stop_v)  level <= 1'b0;
        else if (cnt == start_v) level <= 1'b1;
    end

    assert_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == start_v && cnt != stop_v) |=> level);
    assert_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == stop_v) |=> !level);
endmodule

// File: rtl/pwm_pad_stage.sv
// Maps the level to pin value and drive enable: invert, drive mode, idle state.
// Assumes: a released pin reports pad_val = 0.
module pwm_pad_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       invert,
    input  logic       drive_totem,
    input  logic [1:0] idle_sel,
    input  logic       out_en_n,
    output logic       pad_val,
    output logic       pad_oe
);
    logic shown;

    // Pick the pin behaviour for enabled and disabled operation.
    always_comb begin
        shown   = level ^ invert;
        pad_val = 1'b0;
        pad_oe  = 1'b1;
        if (!out_en_n) begin
            if (drive_totem) pad_val = shown;
            else             pad_oe  = !shown;
        end else begin
            if (idle_sel[1])                     pad_oe  = 1'b0;
            else if (idle_sel[0] && drive_totem) pad_val = 1'b1;
            else if (idle_sel[0])                pad_oe  = 1'b0;
        end
    end

    assert_od_never_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_totem |-> !(pad_oe && pad_val));
    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_n && idle_sel[1]) |-> !pad_oe);
endmodule

// File: rtl/pwm_phase_chan.sv
// One phase-programmable PWM channel: counter, shadow/active registers,
// edge comparator and pad stage.
// Assumes: synchronous active-low reset; CNT_W between 9 and 16.
module pwm_phase_chan #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             bus_stop,
    input  logic             commit_on_ack,
    input  logic             invert,
    input  logic             drive_totem,
    input  logic [1:0]       idle_sel,
    input  logic             out_en_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pad_val,
    output logic             pad_oe
);
    logic [CNT_W-1:0] start_act, stop_act;
    logic             level;

    pwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_o)
    );

    pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bus_stop(bus_stop), .commit_on_ack(commit_on_ack),
        .start_act(start_act), .stop_act(stop_act)
    );

    pwm_edge_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_o), .start_v(start_act),
        .stop_v(stop_act), .level(level)
    );

    pwm_pad_stage u_pad (
        .clk(clk), .rst_n(rst_n), .level(level), .invert(invert),
        .drive_totem(drive_totem), .idle_sel(idle_sel), .out_en_n(out_en_n),
        .pad_val(pad_val), .pad_oe(pad_oe)
    );
endmodule

// File: tb/pwm_phase_chan_tb.sv
// Directed bench for pwm_phase_chan: one task per scenario.
module pwm_phase_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        bus_stop = 1'b0;
    logic        commit_on_ack = 1'b0;
    logic        invert = 1'b0;
    logic        drive_totem = 1'b1;
    logic [1:0]  idle_sel = 2'd0;
    logic        out_en_n = 1'b0;
    logic [11:0] cnt_o;
    logic        pad_val, pad_oe;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    pwm_phase_chan dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bus_stop(bus_stop), .commit_on_ack(commit_on_ack),
        .invert(invert), .drive_totem(drive_totem), .idle_sel(idle_sel),
        .out_en_n(out_en_n), .cnt_o(cnt_o), .pad_val(pad_val), .pad_oe(pad_oe)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_errors++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    // Expected level shown while the count reads c (R2).
    function automatic logic exp_level(input logic [11:0] c, input logic [11:0] on_v,
                                       input logic [11:0] off_v);
        logic [11:0] p;
        p = c - 12'd1;
        if (on_v == off_v) return 1'b0;
        if (on_v < off_v)  return (p >= on_v) && (p < off_v);
        return (p >= on_v) || (p < off_v);
    endfunction

    // Expected pad {val, oe} from the level and the current modes (R7, R8, R9).
    function automatic logic [1:0] exp_pad(input logic lvl);
        logic s;
        s = lvl ^ invert;
        if (!out_en_n) begin
            if (drive_totem) return {s, 1'b1};
            return s ? 2'b00 : 2'b01;
        end
        if (idle_sel[1]) return 2'b00;
        if (idle_sel[0]) return drive_totem ? 2'b11 : 2'b00;
        return 2'b01;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Optionally settle a period, then compare the pad on every cycle of one period.
    task automatic check_period(input string tag, input logic [11:0] on_v,
                                input logic [11:0] off_v, input bit settle);
        int bad = 0;
        logic [1:0] first_act = 2'b00, first_exp = 2'b00;
        if (settle) repeat (4096) @(negedge clk);
        for (int i = 0; i < 4096; i++) begin
            logic [1:0] e;
            @(negedge clk);
            e = exp_pad(exp_level(cnt_o, on_v, off_v));
            if ({pad_val, pad_oe} !== e) begin
                if (bad == 0) begin
                    first_act = {pad_val, pad_oe};
                    first_exp = e;
                end
                bad++;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_errors++;
            $display("FAIL %s: %0d bad cycles, actual pad=%b expected pad=%b",
                     tag, bad, first_act, first_exp);
        end
    endtask

    task automatic wr_byte(input logic [1:0] sel, input logic [7:0] d, input bit with_stop);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; bus_stop = with_stop;
        @(negedge clk);
        wr_en = 1'b0; bus_stop = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 count after reset", cnt_o, 12'd1);
        check("R6 pad after reset", {pad_val, pad_oe}, 2'b01);
        while (cnt_o != 12'd4095) @(negedge clk);
        @(negedge clk);
        check("R1 wrap to zero", cnt_o, 12'd0);
        check_period("R6 level low before commit", 12'd0, 12'd0, 1'b0);
    endtask

    task automatic t_basic();
        wr_byte(2'd0, 8'd100, 0); wr_byte(2'd1, 8'h00, 0);
        wr_byte(2'd2, 8'h2C, 0);  wr_byte(2'd3, 8'h01, 0);
        pulse_stop();
        check_period("R2 window 100..300", 12'd100, 12'd300, 1'b1);
    endtask

    task automatic t_wrap();
        wr_byte(2'd3, 8'h00, 0); wr_byte(2'd2, 8'd50, 0);
        wr_byte(2'd1, 8'h0F, 0); wr_byte(2'd0, 8'hA0, 0);
        pulse_stop();
        check_period("R2 window wraps 4000..50", 12'd4000, 12'd50, 1'b1);
    endtask

    task automatic t_high_byte();
        wr_byte(2'd0, 8'h10, 0); wr_byte(2'd1, 8'hF2, 0);
        wr_byte(2'd2, 8'h20, 0); wr_byte(2'd3, 8'hA3, 0);
        pulse_stop();
        check_period("R3 high bits 7:4 ignored", 12'h210, 12'h320, 1'b1);
    endtask

    task automatic t_stop_mode();
        wr_byte(2'd3, 8'h05, 0);
        check_period("R4 no change before stop", 12'h210, 12'h320, 1'b0);
        pulse_stop();
        check_period("R4 change at stop", 12'h210, 12'h520, 1'b1);
        wr_byte(2'd0, 8'h00, 1);
        check_period("R4 byte with stop included", 12'h200, 12'h520, 1'b1);
    endtask

    task automatic t_ack_mode();
        @(negedge clk); commit_on_ack = 1'b1;
        wr_byte(2'd0, 8'h34, 0); wr_byte(2'd1, 8'h01, 0); wr_byte(2'd2, 8'h78, 0);
        check_period("R5 three bytes no change", 12'h200, 12'h520, 1'b0);
        pulse_stop();
        wr_byte(2'd3, 8'h06, 0);
        check_period("R5 stop clears record", 12'h200, 12'h520, 1'b0);
        wr_byte(2'd3, 8'h06, 0); wr_byte(2'd2, 8'h78, 0);
        wr_byte(2'd1, 8'h01, 0); wr_byte(2'd0, 8'h34, 0);
        check_period("R5 four bytes commit", 12'h134, 12'h678, 1'b1);
        @(negedge clk); commit_on_ack = 1'b0;
    endtask

    task automatic t_equal();
        wr_byte(2'd2, 8'h34, 0); wr_byte(2'd3, 8'h01, 0);
        pulse_stop();
        check_period("R2 start equals stop stays low", 12'h134, 12'h134, 1'b1);
        wr_byte(2'd2, 8'h78, 0); wr_byte(2'd3, 8'h06, 0);
        pulse_stop();
        repeat (4096) @(negedge clk);
    endtask

    task automatic t_pad_modes();
        @(negedge clk); invert = 1'b1;
        check_period("R7 inverted level", 12'h134, 12'h678, 1'b0);
        @(negedge clk); invert = 1'b0; drive_totem = 1'b0;
        check_period("R8 open-drain drive", 12'h134, 12'h678, 1'b0);
        @(negedge clk); out_en_n = 1'b1; idle_sel = 2'b00; drive_totem = 1'b1;
        @(negedge clk); check("R9 idle 00 drives 0", {pad_val, pad_oe}, 2'b01);
        idle_sel = 2'b01;
        @(negedge clk); check("R9 idle 01 totem drives 1", {pad_val, pad_oe}, 2'b11);
        drive_totem = 1'b0;
        @(negedge clk); check("R9 idle 01 open-drain released", {pad_val, pad_oe}, 2'b00);
        idle_sel = 2'b10; drive_totem = 1'b1;
        @(negedge clk); check("R9 idle 10 released", {pad_val, pad_oe}, 2'b00);
        idle_sel = 2'b11;
        @(negedge clk); check("R9 idle 11 released", {pad_val, pad_oe}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_high_byte();
        t_stop_mode();
        t_ack_mode();
        t_equal();
        t_pad_modes();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule